// File: doc/BRIEF.md
# TAP Clock Burst Generator

This block is one command unit of a test access port master. It takes command words from a FIFO-style valid/ready input and turns each one into a train of pulses on the board test clock. The test mode select line is held at one fixed level for the whole train. The main command asks for N clocks with mode select held low, which is what a built-in self-test run needs while the target sits in Run-Test/Idle. N comes from the 32-bit data word and is loaded into a down-counter. Three sibling commands share the same machinery. Two give one clock with mode select at a chosen level, which steps the target state machine by one arc. The third gives a fixed number of clocks with mode select high, which drives any target TAP into Test-Logic-Reset.

A small four-state Moore sequencer drives the pulses. Each test clock pulse takes two system clocks: one low and one high. The counter is decremented in the high state. When the count reaches zero the block raises a one-cycle completion strobe and then takes the next command.

Top module: `tcb_burst_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `tck_o` is 0, `tms_o` is 1, `done_o` is 0 and `cmd_ready` is 1.
- R2: `cmd_ready` is 1 only while the block is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. A command held valid while the block is busy is not taken until the current one has completed.
- R3: Opcode 2'b00 (burst) produces exactly N test clock pulses, where N is the full 32-bit value on `cmd_data` at acceptance.
- R4: During a burst `tms_o` is 0 at every pulse. `tms_o` does not change while `tck_o` is high.
- R5: Each pulse is high for exactly one system clock and is preceded by at least one low system clock.
- R6: The internal pulse count falls by exactly one per pulse and never wraps below zero, so long bursts (N = 40) keep the exact pulse count.
- R7: A burst with N = 0 produces no pulse and completes two cycles after acceptance.
- R8: `done_o` is high for exactly one cycle, 2N+2 cycles after the accepting edge for a command of N pulses. `cmd_ready` returns to 1 on the following cycle.
- R9: Opcode 2'b01 gives one pulse with `tms_o` = 0 and opcode 2'b10 gives one pulse with `tms_o` = 1. `cmd_data` is ignored by both.
- R10: Opcode 2'b11 (TAP reset) gives RST_PULSES pulses (default 5) with `tms_o` = 1. `cmd_data` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Block is idle and takes the word this cycle |
| cmd_op | input | 2 | Command opcode |
| cmd_data | input | DATA_W | Pulse count for the burst opcode |
| tck_o | output | 1 | Board test clock |
| tms_o | output | 1 | Board test mode select |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume three things about the inputs:
- Reset is released away from a clock edge.
- `cmd_op` and `cmd_data` are stable on the edge where `cmd_valid` meets `cmd_ready`.
- Nothing outside the valid/ready exchange loads or disturbs the pulse counter.

The stimulus changes its inputs only on falling clock edges and holds each command until it sees `cmd_ready`. It also keeps `cmd_valid` high across consecutive commands, so that the hold-off during busy periods is exercised. Counts are kept small enough that a full burst fits well inside the run.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

  typedef enum logic [1:0] {
    OP_BURST  = 2'b00,
    OP_TMS_LO = 2'b01,
    OP_TMS_HI = 2'b10,
    OP_RESET  = 2'b11
  } tcb_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LOW  = 2'b01,
    ST_HIGH = 2'b10,
    ST_DONE = 2'b11
  } tcb_state_e;

endpackage

// File: rtl/tcb_decode.sv
module tcb_decode
  import tcb_pkg::*;
#(
  parameter int W          = 32,
  parameter int RST_PULSES = 5
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] count_o,
  output logic         tms_o
);

  localparam logic [W-1:0] RstCount = W'(RST_PULSES);
  localparam logic [W-1:0] OneCount = W'(1);

  always_comb begin
    unique case (tcb_op_e'(op_i))
      OP_BURST: begin
        count_o = data_i;
        tms_o   = 1'b0;
      end
      OP_TMS_LO: begin
        count_o = OneCount;
        tms_o   = 1'b0;
      end
      OP_TMS_HI: begin
        count_o = OneCount;
        tms_o   = 1'b1;
      end
      default: begin
        count_o = RstCount;
        tms_o   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/tcb_count.sv
module tcb_count #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i | dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R3: the loaded count is the value presented at load time
  a_r3_load_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));

  // R6: one step down per decrement request
  a_r6_dec_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> (cnt_q == $past(cnt_q) - W'(1)));

  // R6: the sequencer never asks for a decrement at zero
  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);

endmodule

// File: rtl/tcb_seq.sv
module tcb_seq
  import tcb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic zero_i,
  output logic ready_o,
  output logic tck_o,
  output logic dec_o,
  output logic done_o
);

  tcb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LOW;
      ST_LOW:  state_d = zero_i ? ST_DONE : ST_HIGH;
      ST_HIGH: state_d = ST_LOW;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Moore outputs: one fixed control pattern per state
  assign ready_o = (state_q == ST_IDLE);
  assign tck_o   = (state_q == ST_HIGH);
  assign dec_o   = (state_q == ST_HIGH);
  assign done_o  = (state_q == ST_DONE);

  // R5: test clock is high for a single system clock
  a_r5_tck_single_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o |=> !tck_o);

  // R2: no readiness while a pulse or completion is under way
  a_r2_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_o || done_o) |-> !ready_o);

  // R8: completion strobe lasts one cycle and readiness follows it
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));

  // R7: an exhausted count in the low phase ends the command next cycle
  a_r7_zero_finishes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOW && zero_i) |=> done_o);

endmodule

// File: rtl/tcb_burst_gen.sv
module tcb_burst_gen
  import tcb_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RST_PULSES = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              tck_o,
  output logic              tms_o,
  output logic              done_o
);

  logic              start;
  logic              zero;
  logic              dec;
  logic [DATA_W-1:0] load_val;
  logic              tms_sel;
  logic              tms_q;

  assign start = cmd_valid & cmd_ready;

  tcb_decode #(
    .W          (DATA_W),
    .RST_PULSES (RST_PULSES)
  ) u_decode (
    .op_i    (cmd_op),
    .data_i  (cmd_data),
    .count_o (load_val),
    .tms_o   (tms_sel)
  );

  tcb_count #(
    .W (DATA_W)
  ) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_val_i (load_val),
    .dec_i      (dec),
    .zero_o     (zero)
  );

  tcb_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .zero_i  (zero),
    .ready_o (cmd_ready),
    .tck_o   (tck_o),
    .dec_o   (dec),
    .done_o  (done_o)
  );

  // mode select level is captured once per command and held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tms_q <= 1'b1;
    end else if (start) begin
      tms_q <= tms_sel;
    end
  end

  assign tms_o = tms_q;

  // R4: mode select never moves while the test clock is high
  a_r4_tms_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o |-> $stable(tms_o));

  // R4: a pulse never coincides with a new command being taken
  a_r4_no_start_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o |-> !start);

endmodule

// File: tb/tb_tcb_burst_gen.sv
`timescale 1ns/1ps
module tb_tcb_burst_gen;

  localparam int DATA_W = 32;
  localparam int RSTP   = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid;
  logic              cmd_ready;
  logic [1:0]        cmd_op;
  logic [DATA_W-1:0] cmd_data;
  logic              tck_o, tms_o, done_o;

  always #2.5 clk = ~clk;

  tcb_burst_gen #(.DATA_W(DATA_W), .RST_PULSES(RSTP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .tck_o(tck_o), .tms_o(tms_o),
    .done_o(done_o));

  typedef struct {
    int    pulses;
    bit    tms;
    int    start;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  int   cyc = 0;
  int   pulse_cnt = 0;
  bit   tms_err = 0;
  bit   prev_tck = 0;
  bit   ended = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (prev_tck) chk(!tck_o, "R5 tck high one cycle", int'(tck_o), 0);
      if (tck_o && !prev_tck) begin
        pulse_cnt++;
        chk(!cmd_ready, "R2 not ready during pulse", int'(cmd_ready), 0);
        if (q.size() > 0 && tms_o !== q[0].tms) tms_err = 1;
      end
      prev_tck = tck_o;
      if (done_o) begin
        if (q.size() == 0) begin
          chk(0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(pulse_cnt == e.pulses, {e.tag, " pulse count"}, pulse_cnt, e.pulses);
          chk(!tms_err, {e.tag, " R4 tms level"}, int'(tms_err), 0);
          chk(cyc - e.start == 2*e.pulses + 2, {e.tag, " R8 done latency"},
              cyc - e.start, 2*e.pulses + 2);
        end
        pulse_cnt = 0;
        tms_err   = 0;
      end
    end
  end

  // driver: presents a command and holds it until taken; valid stays high
  task automatic send(logic [1:0] op, logic [DATA_W-1:0] data, int pulses,
                      bit tms, string tag);
    exp_t e;
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = data;
    while (!cmd_ready) @(negedge clk);
    e.pulses = pulses;
    e.tms    = tms;
    e.start  = cyc;
    e.tag    = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic drain();
    cmd_valid = 1'b0;
    for (int i = 0; i < 2000 && q.size() > 0; i++) @(negedge clk);
    chk(q.size() == 0, "R8 all commands completed", q.size(), 0);
  endtask

  task automatic summary();
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_op    = 2'b00;
    cmd_data  = '0;
    repeat (3) @(negedge clk);
    chk(tck_o == 0, "R1 tck in reset", int'(tck_o), 0);
    chk(tms_o == 1, "R1 tms in reset", int'(tms_o), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == 0, "R1 done after reset", int'(done_o), 0);
    chk(cmd_ready == 1, "R1 ready after reset", int'(cmd_ready), 1);
    chk(tck_o == 0, "R1 tck after reset", int'(tck_o), 0);

    send(2'b00, 32'd3, 3, 1'b0, "R3 burst3");
    drain();
    send(2'b00, 32'd0, 0, 1'b0, "R7 burst0");
    drain();
    send(2'b01, 32'hFFFF_FFFF, 1, 1'b0, "R9 tms_lo");
    drain();
    send(2'b10, 32'd7, 1, 1'b1, "R9 tms_hi");
    drain();
    send(2'b11, 32'd100, RSTP, 1'b1, "R10 tap_reset");
    drain();
    send(2'b00, 32'd1, 1, 1'b0, "R4 burst1 after reset");
    drain();
    send(2'b00, 32'd40, 40, 1'b0, "R6 burst40");
    drain();
    // back-to-back with valid held high through busy periods
    send(2'b00, 32'd2, 2, 1'b0, "R2 b2b burst2");
    send(2'b10, 32'd9, 1, 1'b1, "R2 b2b tms_hi");
    send(2'b00, 32'd0, 0, 1'b0, "R2 b2b burst0");
    send(2'b11, 32'd0, RSTP, 1'b1, "R10 b2b reset");
    drain();
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1, "R8 ready when idle", int'(cmd_ready), 1);
    summary();
  end

endmodule